// File: doc/BRIEF.md
# SHA-256 Message Padding Unit

This block sits in front of a SHA-256 compression engine. Message bytes arrive one per beat on a valid/ready handshake, and a last-beat marker ends each message. The unit packs the bytes into 512-bit blocks and counts the message length in bits. At the end of the message it adds the padding that SHA-256 requires: a single one bit, then zero fill, then the bit length as a 64-bit big-endian number in the low 64 bits of the closing block. Each block leaves through its own valid/ready handshake. A flag marks the block that closes the message.

The one bit always lands on a byte boundary, so it appears as the byte 0x80. When fewer than nine bytes of room remain after the last data byte, the length field cannot fit in that block. The unit then emits one more block of zeros that carries the length. An empty message is sent as a single last beat flagged as carrying no byte.

Top module: `sha256_pad_unit`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Bytes are packed big-endian, so byte k of a block occupies bits 511-8k down to 504-8k. After 64 bytes without in_last, the block goes out unchanged with out_final 0.
- R3: The byte that follows the last data byte is 0x80. Every later byte up to the length field, or up to the end of the block, is 0x00.
- R4: The closing block carries the message length in bits in out_block[63:0], most significant byte first. out_final is 1 on that block and on no other block.
- R5: If the closing data block holds 56 to 63 bytes, that block is completed by the marker and zero fill and has out_final 0. It is followed by a block of zeros that ends with the length field.
- R6: If the message length is a nonzero multiple of 64 bytes, the last data block goes out unmodified. It is followed by a block whose first byte is 0x80, with zeros after it and the length field at the end.
- R7: A beat with in_valid, in_last and in_void all 1 carries no byte. Sent alone, it produces one block: 0x80, then zeros, then a zero length field.
- R8: While out_valid is 1 and out_ready is 0, out_block and out_final hold their values and in_ready stays 0.
- R9: The length count returns to zero once the closing block is accepted, so each message's length field counts only its own bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input beat is present |
| in_ready | output | 1 | Unit can take an input beat |
| in_data | input | 8 | Message byte |
| in_last | input | 1 | Beat ends the message |
| in_void | input | 1 | With in_last: the beat carries no byte |
| out_valid | output | 1 | A block is presented |
| out_ready | input | 1 | Consumer takes the block |
| out_block | output | 512 | Block, first byte in the top bits |
| out_final | output | 1 | Block closes the message and holds the length |

## Verification
The assertions check, on every cycle, the following properties:
- A stalled block stays unchanged.
- The 64th byte of a block that is not the last block raises out_valid without the final flag.
- An overflow block is always followed, two cycles after its hand-off, by a final block.
- The length count is zero after a final hand-off.

Only the bench's scenarios can show the following:
- The exact placement of data, the marker byte, the zero fill and the big-endian length field.
- The choice between one and two closing blocks.
- The empty-message case.

The bench covers these by sweeping every message length from 0 to 130 bytes, which reaches every remainder modulo 64 and several multi-block messages.

// File: rtl/pad_pkg.sv
package pad_pkg;
  typedef enum logic [1:0] {
    ST_FILL = 2'd0,
    ST_PAD  = 2'd1,
    ST_SEND = 2'd2
  } pad_state_e;
endpackage

// File: rtl/pad_len_ctr.sv
// Running message length in bits; advances one byte width per accepted byte.
module pad_len_ctr #(
  parameter int LEN_W  = 64,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [LEN_W-1:0] bit_len
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = clr | inc;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + LEN_W'(BYTE_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign bit_len = cnt_q;
endmodule

// File: rtl/pad_block_fmt.sv
// Builds a padded block from the bytes gathered so far.
module pad_block_fmt #(
  parameter int BYTE_W  = 8,
  parameter int BLOCK_W = 512,
  parameter int LEN_W   = 64,
  localparam int NBYTES    = BLOCK_W / BYTE_W,
  localparam int LEN_BYTES = LEN_W / BYTE_W,
  localparam int FIT_LIMIT = NBYTES - LEN_BYTES,
  localparam int IDX_W     = $clog2(NBYTES + 1)
) (
  input  logic [BLOCK_W-1:0] blk_in,
  input  logic [IDX_W-1:0]   used,
  input  logic               mark_done,
  input  logic [LEN_W-1:0]   bit_len,
  output logic [BLOCK_W-1:0] blk_out,
  output logic               len_fits
);
  localparam logic [BYTE_W-1:0] MARKER = {1'b1, {(BYTE_W-1){1'b0}}};

  logic [IDX_W:0] need;

  always_comb begin
    need     = {1'b0, used} + (IDX_W+1)'(!mark_done);
    len_fits = need <= (IDX_W+1)'(FIT_LIMIT);
  end

  always_comb begin
    blk_out = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (len_fits && i >= FIT_LIMIT)
        blk_out[(NBYTES-1-i)*BYTE_W +: BYTE_W] = bit_len[(NBYTES-1-i)*BYTE_W +: BYTE_W];
      else if (IDX_W'(i) < used)
        blk_out[(NBYTES-1-i)*BYTE_W +: BYTE_W] = blk_in[(NBYTES-1-i)*BYTE_W +: BYTE_W];
      else if (IDX_W'(i) == used && !mark_done)
        blk_out[(NBYTES-1-i)*BYTE_W +: BYTE_W] = MARKER;
    end
  end
endmodule

// File: rtl/sha256_pad_unit.sv
module sha256_pad_unit #(
  parameter int BYTE_W  = 8,
  parameter int BLOCK_W = 512,
  parameter int LEN_W   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [BYTE_W-1:0]  in_data,
  input  logic               in_last,
  input  logic               in_void,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [BLOCK_W-1:0] out_block,
  output logic               out_final
);
  import pad_pkg::*;

  localparam int NBYTES = BLOCK_W / BYTE_W;
  localparam int IDX_W  = $clog2(NBYTES + 1);

  // Reset: asserted asynchronously, released through a synchronizer chain.
  logic [SYNC_STAGES-1:0] rs_q;
  logic                   rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rs_q[SYNC_STAGES-1];

  pad_state_e         state_q, state_d;
  logic [BLOCK_W-1:0] blk_q, blk_d;
  logic               blk_we;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic               fin_q, fin_d;
  logic               tail_q, tail_d;   // message end seen, closing block(s) pending
  logic               mark_q, mark_d;   // marker byte already placed

  logic               accept, has_byte, out_take, len_clr;
  logic [LEN_W-1:0]   bit_len;
  logic [BLOCK_W-1:0] fmt_blk;
  logic               fmt_fits;

  assign in_ready  = (state_q == ST_FILL);
  assign out_valid = (state_q == ST_SEND);
  assign out_block = blk_q;
  assign out_final = fin_q;

  assign accept   = in_valid & in_ready;
  assign has_byte = accept & ~(in_last & in_void);
  assign out_take = out_valid & out_ready;
  assign len_clr  = out_take & fin_q;

  pad_len_ctr #(.LEN_W(LEN_W), .BYTE_W(BYTE_W)) u_len (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .inc     (has_byte),
    .clr     (len_clr),
    .bit_len (bit_len)
  );

  pad_block_fmt #(.BYTE_W(BYTE_W), .BLOCK_W(BLOCK_W), .LEN_W(LEN_W)) u_fmt (
    .blk_in    (blk_q),
    .used      (idx_q),
    .mark_done (mark_q),
    .bit_len   (bit_len),
    .blk_out   (fmt_blk),
    .len_fits  (fmt_fits)
  );

  always_comb begin
    state_d = state_q;
    blk_d   = blk_q;
    blk_we  = 1'b0;
    idx_d   = idx_q;
    fin_d   = fin_q;
    tail_d  = tail_q;
    mark_d  = mark_q;
    unique case (state_q)
      ST_FILL: begin
        if (accept) begin
          if (has_byte) begin
            blk_we = 1'b1;
            idx_d  = idx_q + IDX_W'(1);
            for (int i = 0; i < NBYTES; i++)
              if (idx_q == IDX_W'(i)) blk_d[(NBYTES-1-i)*BYTE_W +: BYTE_W] = in_data;
          end
          if (in_last) begin
            tail_d  = 1'b1;
            mark_d  = 1'b0;
            state_d = ST_PAD;
          end else if (idx_q == IDX_W'(NBYTES-1)) begin
            idx_d   = '0;
            fin_d   = 1'b0;
            tail_d  = 1'b0;
            state_d = ST_SEND;
          end
        end
      end
      ST_PAD: begin
        blk_we  = 1'b1;
        blk_d   = fmt_blk;
        fin_d   = fmt_fits;
        mark_d  = mark_q | (idx_q != IDX_W'(NBYTES));
        idx_d   = '0;
        state_d = ST_SEND;
      end
      ST_SEND: begin
        if (out_take) begin
          idx_d = '0;
          if (fin_q) begin
            tail_d  = 1'b0;
            state_d = ST_FILL;
          end else if (tail_q) begin
            state_d = ST_PAD;
          end else begin
            state_d = ST_FILL;
          end
        end
      end
      default: state_d = ST_FILL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_FILL;
      idx_q   <= '0;
      fin_q   <= 1'b0;
      tail_q  <= 1'b0;
      mark_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      fin_q   <= fin_d;
      tail_q  <= tail_d;
      mark_q  <= mark_d;
    end
  end

  // Data register: no reset, written only under its enable.
  always_ff @(posedge clk) begin
    if (blk_we) blk_q <= blk_d;
  end

  AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rst_core_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_block) && $stable(out_final))); // R8

  AST_FULL_BLOCK_OUT: assert property (@(posedge clk) disable iff (!rst_core_n)
    (accept && !in_last && idx_q == IDX_W'(NBYTES-1)) |=> (out_valid && !out_final)); // R2

  AST_SPILL_THEN_FINAL: assert property (@(posedge clk) disable iff (!rst_core_n)
    (out_take && !out_final && tail_q) |-> ##2 (out_valid && out_final)); // R5

  AST_LEN_CLEARED: assert property (@(posedge clk) disable iff (!rst_core_n)
    $past(out_take && out_final) |-> (bit_len == '0)); // R9
endmodule

// File: tb/sha256_pad_unit_tb.sv
`timescale 1ns/1ps
module sha256_pad_unit_tb;
  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [7:0]   in_data;
  logic         in_last;
  logic         in_void;
  logic         out_valid;
  logic         out_ready;
  logic [511:0] out_block;
  logic         out_final;

  int checks;
  int fails;
  logic [511:0] exp_b;
  logic [511:0] snap;

  sha256_pad_unit u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_last   (in_last),
    .in_void   (in_void),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_block (out_block),
    .out_final (out_final)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] data_byte(int len, int k);
    return 8'((k * 7 + len * 3 + 1) & 255);
  endfunction

  function automatic int num_blocks(int len);
    return (len + 9 + 63) / 64;
  endfunction

  function automatic logic [7:0] exp_byte(int len, int j);
    int total;
    logic [63:0] bits;
    total = num_blocks(len) * 64;
    bits  = 64'(len) * 64'd8;
    if (j < len)          return data_byte(len, j);
    if (j == len)         return 8'h80;
    if (j >= total - 8)   return bits[(total - 1 - j) * 8 +: 8];
    return 8'h00;
  endfunction

  function automatic logic [511:0] exp_block(int len, int b);
    logic [511:0] r;
    r = '0;
    for (int i = 0; i < 64; i++) r[(63 - i) * 8 +: 8] = exp_byte(len, b * 64 + i);
    return r;
  endfunction

  function automatic string tag_of(int len, int b);
    int nb;
    nb = num_blocks(len);
    if (len == 0)                 return "R7";
    if ((b + 1) * 64 <= len)      return "R2";
    if (b == nb - 1) begin
      if (len % 64 == 0)          return "R6";
      if (len % 64 >= 56)         return "R5";
      return "R4";
    end
    return "R3";
  endfunction

  task automatic check(bit ok, string tag, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic drive_msg(int len);
    if (len == 0) begin
      in_valid = 1'b1; in_last = 1'b1; in_void = 1'b1; in_data = 8'h5a;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end else begin
      for (int k = 0; k < len; k++) begin
        if (k % 5 == 3) begin
          in_valid = 1'b0;
          @(negedge clk);
        end
        in_valid = 1'b1;
        in_void  = 1'b0;
        in_data  = data_byte(len, k);
        in_last  = (k == len - 1);
        while (!in_ready) @(negedge clk);
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    in_void  = 1'b0;
  endtask

  task automatic recv_msg(int len, string ovr);
    int nb;
    string tg;
    nb = num_blocks(len);
    for (int b = 0; b < nb; b++) begin
      while (!out_valid) @(negedge clk);
      exp_b = exp_block(len, b);
      tg = (ovr != "") ? ovr : tag_of(len, b);
      // R2/R3/R5/R6/R7 block contents
      check(out_block == exp_b, tg,
            $sformatf("len %0d block %0d actual %h expected %h", len, b, out_block, exp_b));
      // R4: final flag only on the last block
      check(out_final == (b == nb - 1), "R4",
            $sformatf("len %0d block %0d final actual %0b expected %0b",
                      len, b, out_final, (b == nb - 1)));
      for (int s = 0; s < (len + b) % 3; s++) begin
        snap = out_block;
        @(negedge clk);
        // R8: held while stalled, input side closed
        check(out_valid && out_block == snap && !in_ready, "R8",
              $sformatf("len %0d stall valid %0b ready_in %0b changed %0b expected 1 0 0",
                        len, out_valid, in_ready, out_block != snap));
      end
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
  endtask

  task automatic run_msg(int len, string ovr);
    fork
      drive_msg(len);
      recv_msg(len, ovr);
    join
  endtask

  initial begin
    checks = 0;
    fails = 0;
    rst_n = 1'b0;
    in_valid = 1'b0; in_data = '0; in_last = 1'b0; in_void = 1'b0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1",
          $sformatf("out_valid %0b in_ready %0b expected 0 1", out_valid, in_ready));
    for (int len = 0; len <= 130; len++) run_msg(len, "");
    // R9: a short message after a long one carries only its own length
    run_msg(70, "");
    run_msg(5, "R9");
    run_msg(0, "R9");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule